// File: doc/BRIEF.md
# Programmable parallel port channel with handshake

This block is one channel of a parallel peripheral interface. A processor reaches it over an 8-bit data bus with a single register-select line, read and write strobes and an enable that qualifies each bus cycle. Inside are a configuration register, a direction register and an output register. The channel drives an 8-bit peripheral port as separate input, output and output-enable vectors, so the pads can be built outside the block.

Two control lines support handshaking with the peripheral. Line 1 is always an edge-sensitive input that raises a status flag. Line 2 is either a second edge-sensitive input or an output. As an output it works in one of three ways: an automatic write handshake, a one-cycle strobe, or a level set by software. The interrupt request output is active low. It is asserted whenever an enabled flag is pending. The flags cannot be written by the processor. A read of the peripheral register clears them.

Top module: `pport_channel`

## Requirements
- R1: After reset every register is zero: pin_oe = 0x00, irq_n = 1, cl2_oe = 0, the configuration register reads 0x00 and the direction register reads 0x00.
- R2: With rs = 0, configuration bit 2 steers the access. When it is 0, the access reaches the direction register. When it is 1, it reaches the output register on writes and the peripheral register on reads. Writing one of these registers leaves the other unchanged.
- R3: pin_oe equals the direction register (1 = output, 0 = input), and pin_out equals the output register.
- R4: A read of the peripheral register returns the live pin_in value on input bits and the output register on output bits. Input bits are not latched.
- R5: Configuration bit 1 picks the active edge of cl1_in (1 = rising, 0 = falling). An active edge sets flag 1, read as configuration bit 7, whatever the enable bit 0 holds. The other edge does not set the flag.
- R6: A read of the peripheral register clears both flags (bits 7 and 6). A read at rs = 0 while bit 2 = 0 is a read of the direction register and leaves the flags set.
- R7: Processor writes with rs = 1 update only bits 5..0. Bits 7 and 6 keep their flag values.
- R8: irq_n is low exactly when flag 1 is set with bit 0 = 1, or flag 2 is set with bit 3 = 1 while bit 5 = 0.
- R9: With bit 5 = 0, cl2_in is an input. Bit 4 picks its active edge (1 = rising), the edge sets flag 2 (bit 6), and cl2_oe = 0.
- R10: With bit 5 = 1 and bits 4 and 3 = 0, cl2_oe = 1. cl2_out goes low after a write to the output register and returns high on the next active edge of cl1_in.
- R11: With bit 5 = 1, bit 4 = 0 and bit 3 = 1, cl2_out goes low after a write to the output register. It returns high after the next clock edge on which en is high. Cycles with en low keep it low.
- R12: With bits 5 and 4 both 1, cl2_out follows bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Bus cycle enable |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| rs | input | 1 | Register select: 1 = configuration, 0 = shared data address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| pin_in | input | 8 | Peripheral pin levels |
| pin_out | output | 8 | Peripheral output values |
| pin_oe | output | 8 | Peripheral output enables |
| cl1_in | input | 1 | Control line 1 input |
| cl2_in | input | 1 | Control line 2 input |
| cl2_out | output | 1 | Control line 2 output value |
| cl2_oe | output | 1 | Control line 2 output enable |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check on every cycle the properties that hold over time. An active cl1_in edge always sets flag 1, and flag 1 survives every cycle that is not a peripheral read. A clearing read with quiet control lines empties both flags. irq_n can only fall while a flag is pending. A handshake write always pulls cl2_out low, and manual mode keeps cl2_out steady while the configuration is unchanged. Only the bench scenarios show the rest: the read-back values under different direction and pin patterns, the rejected edge polarity, the restore timing of the handshake and strobe modes, and the masking of flag bits on configuration writes.

// File: rtl/pport_channel.sv
module pport_channel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rd,
  input  logic       wr,
  input  logic       rs,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe,
  input  logic       cl1_in,
  input  logic       cl2_in,
  output logic       cl2_out,
  output logic       cl2_oe,
  output logic       irq_n
);
  logic [5:0] cfg;
  logic [7:0] ddr, orr;
  logic       flg1, flg2, c1q, c2q, hs;

  wire wr_cfg = en & wr & rs;
  wire wr_dat = en & wr & ~rs;
  wire rd_per = en & rd & ~rs & cfg[2];
  wire e1 = (cl1_in ^ c1q) & (cl1_in == cfg[1]);
  wire e2 = ~cfg[5] & (cl2_in ^ c2q) & (cl2_in == cfg[4]);
  wire m_hs = cfg[5] & ~cfg[4] & ~cfg[3];
  wire m_pl = cfg[5] & ~cfg[4] & cfg[3];

  always_ff @(posedge clk) begin
    c1q <= cl1_in;
    c2q <= cl2_in;
    if (!rst_n) begin
      cfg  <= '0;
      ddr  <= '0;
      orr  <= '0;
      flg1 <= 1'b0;
      flg2 <= 1'b0;
      hs   <= 1'b1;
    end else begin
      if (wr_cfg) cfg <= din[5:0];
      if (wr_dat) begin
        if (cfg[2]) orr <= din;
        else        ddr <= din;
      end
      flg1 <= e1 | (flg1 & ~rd_per);
      flg2 <= e2 | (flg2 & ~rd_per);
      if (wr_dat & cfg[2] & (m_hs | m_pl)) hs <= 1'b0;
      else if ((m_hs & e1) | (m_pl & en)) hs <= 1'b1;
    end
  end

  assign pin_out = orr;
  assign pin_oe  = ddr;
  assign dout    = rs ? {flg1, flg2, cfg} :
                   cfg[2] ? ((pin_in & ~ddr) | (orr & ddr)) : ddr;
  assign cl2_oe  = cfg[5];
  assign cl2_out = cfg[4] ? cfg[3] : hs;
  assign irq_n   = ~((flg1 & cfg[0]) | (flg2 & cfg[3] & ~cfg[5]));
endmodule

// File: rtl/pport_channel_chk.sv
module pport_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       rd,
  input logic       wr,
  input logic       rs,
  input logic       cl1_in,
  input logic       cl2_in,
  input logic       cl2_out,
  input logic       irq_n,
  input logic [5:0] cfg,
  input logic       flg1,
  input logic       flg2
);
  p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cl1_in) && cfg[1] |=> flg1);
  p_fall_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cl1_in) && !cfg[1] |=> flg1);
  p_flag_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flg1 && !(en && rd && !rs && cfg[2]) |=> flg1);
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en && rd && !rs && cfg[2] && $stable(cl1_in) && $stable(cl2_in) |=> !flg1 && !flg2);
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> flg1 || flg2);
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flg1 && !flg2 |-> irq_n);
  p_hs_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[5] && !cfg[4] && en && wr && !rs && cfg[2] |=> !cl2_out);
  p_manual_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[5] && cfg[4] && $stable(cfg) |-> $stable(cl2_out));
endmodule

bind pport_channel pport_channel_chk u_chk (.*);

// File: tb/pport_channel_test.sv
`timescale 1ns/1ps
module pport_channel_test;
  logic clk = 0, rst_n = 0, en = 0, rd = 0, wr = 0, rs = 0;
  logic cl1_in = 0, cl2_in = 0;
  logic [7:0] din = 0, pin_in = 0;
  logic [7:0] dout, pin_out, pin_oe;
  logic cl2_out, cl2_oe, irq_n;
  int checks = 0, errors = 0;
  logic [7:0] r;

  always #2.5 clk = ~clk;

  pport_channel uut (.clk, .rst_n, .en, .rd, .wr, .rs, .din, .dout, .pin_in,
    .pin_out, .pin_oe, .cl1_in, .cl2_in, .cl2_out, .cl2_oe, .irq_n);

  // {ddr, orr, pins}
  localparam logic [23:0] VEC [6] = '{24'h00FFA5, 24'hFF3C00, 24'h0F96F0,
                                      24'hF05A0F, 24'hAAFF55, 24'h817EC3};

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic s, logic [7:0] d);
    @(negedge clk); en = 1; wr = 1; rs = s; din = d;
    @(negedge clk); en = 0; wr = 0;
  endtask

  task automatic bus_rd(logic s, output logic [7:0] d);
    @(negedge clk); en = 1; rd = 1; rs = s;
    #1 d = dout;
    @(negedge clk); en = 0; rd = 0;
  endtask

  task automatic set_cl1(logic v);
    @(negedge clk); cl1_in = v;
    @(negedge clk);
  endtask

  task automatic set_cl2(logic v);
    @(negedge clk); cl2_in = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    check("R1 cl2_oe", {7'd0, cl2_oe}, 8'h00);
    bus_rd(1, r); check("R1 cfg", r, 8'h00);
    bus_rd(0, r); check("R1 ddr", r, 8'h00);

    for (int i = 0; i < 6; i++) begin
      logic [7:0] d, o, p;
      {d, o, p} = VEC[i];
      bus_wr(1, 8'h00); bus_wr(0, d);
      bus_wr(1, 8'h04); bus_wr(0, o);
      pin_in = p;
      bus_rd(0, r); check("R4 read merge", r, (p & ~d) | (o & d));
      check("R3 pin_oe", pin_oe, d);
      check("R3 pin_out", pin_out, o);
      pin_in = ~p;
      bus_rd(0, r); check("R4 live pins", r, (~p & ~d) | (o & d));
      bus_wr(1, 8'h00);
      bus_rd(0, r); check("R2 ddr kept", r, d);
    end

    bus_wr(1, 8'h00); bus_wr(0, 8'h00);
    bus_wr(1, 8'h06);
    set_cl1(1);
    bus_rd(1, r); check("R5 rising sets flag", r, 8'h86);
    check("R8 masked irq", {7'd0, irq_n}, 8'h01);
    bus_wr(1, 8'h02);
    bus_rd(0, r);
    bus_rd(1, r); check("R6 ddr read keeps flag", r, 8'h82);
    bus_wr(1, 8'h06);
    bus_rd(0, r);
    bus_rd(1, r); check("R6 read clears flag", r, 8'h06);
    set_cl1(0);
    bus_rd(1, r); check("R5 wrong edge ignored", r, 8'h06);
    bus_wr(1, 8'h04);
    set_cl1(1);
    bus_rd(1, r); check("R5 rising ignored when falling picked", r, 8'h04);
    set_cl1(0);
    bus_rd(1, r); check("R5 falling sets flag", r, 8'h84);

    bus_wr(1, 8'h04);
    bus_rd(1, r); check("R7 write keeps flag", r, 8'h84);
    bus_rd(0, r);
    bus_wr(1, 8'hC4);
    bus_rd(1, r); check("R7 flag bits not writable", r, 8'h04);

    bus_wr(1, 8'h07);
    set_cl1(1);
    check("R8 irq asserted", {7'd0, irq_n}, 8'h00);
    bus_rd(0, r);
    check("R8 irq released", {7'd0, irq_n}, 8'h01);
    set_cl1(0);

    bus_wr(1, 8'h1C);
    check("R9 cl2_oe input", {7'd0, cl2_oe}, 8'h00);
    set_cl2(1);
    bus_rd(1, r); check("R9 cl2 flag", r, 8'h5C);
    check("R8 irq from line 2", {7'd0, irq_n}, 8'h00);
    bus_rd(0, r);
    check("R8 irq line 2 cleared", {7'd0, irq_n}, 8'h01);
    set_cl2(0);
    bus_rd(1, r); check("R9 wrong edge ignored", r, 8'h1C);

    bus_wr(1, 8'h24);
    check("R10 cl2_oe", {7'd0, cl2_oe}, 8'h01);
    check("R10 idle high", {7'd0, cl2_out}, 8'h01);
    bus_wr(0, 8'h12);
    check("R10 low after write", {7'd0, cl2_out}, 8'h00);
    repeat (3) @(negedge clk);
    check("R10 holds low", {7'd0, cl2_out}, 8'h00);
    set_cl1(1);
    check("R10 inactive edge", {7'd0, cl2_out}, 8'h00);
    set_cl1(0);
    check("R10 restored by edge", {7'd0, cl2_out}, 8'h01);

    bus_wr(1, 8'h2C);
    bus_wr(0, 8'h34);
    check("R11 strobe low", {7'd0, cl2_out}, 8'h00);
    @(negedge clk);
    check("R11 low without enable", {7'd0, cl2_out}, 8'h00);
    bus_rd(1, r);
    check("R11 high after enable cycle", {7'd0, cl2_out}, 8'h01);

    bus_wr(1, 8'h38);
    check("R12 manual high", {7'd0, cl2_out}, 8'h01);
    bus_wr(1, 8'h30);
    check("R12 manual low", {7'd0, cl2_out}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule